// File: doc/BRIEF.md
# PCM Serial Transmit Port with Frame-Sync Width Detection

This block sends one 8-bit PCM code word per frame on a serial data line with a separate output-enable, so the line can share a bus with other transmitters. A transmit bit clock and a transmit frame-sync pulse set the timing. Both are sampled in the block's own fast system clock. Software or an upstream encoder writes the next word into a staging register with a load strobe. At the start of each frame that word moves into the shifter and goes out sign bit first.

The port measures the width of every frame-sync pulse. It counts how many falling bit-clock edges see the sync high. One or two of them mark a short sync, three or more mark a long sync. The classification is applied from the following frame onward.

- In short mode, a sync seen high on a falling edge makes the next rising edge start the word. The line is released on the falling edge after the last bit.
- In long mode, the word starts on whichever comes later: the sync rising edge or the bit-clock rising edge. The line is released a full eight bit periods after the start.

A power-up permission input drops the enable at once, aborts any word in flight and returns the port to short mode.

Top module: `pcm_tx_port`

## Requirements
- R1: After reset `dx_oe_o` and `dx_o` are 0 and the port is in short mode.
- R2: In short mode, a falling bit-clock edge that sees `fsync_i` high as the first such edge of that pulse arms the port. The next rising bit-clock edge sets `dx_oe_o` and drives bit 7 (the sign bit) on `dx_o`.
- R3: Each of the seven rising bit-clock edges after the first bit shifts the next lower bit onto `dx_o`, in order from bit 6 down to bit 0.
- R4: In short mode `dx_oe_o` clears on the first falling bit-clock edge after the rising edge that drove bit 0.
- R5: At each falling edge of `fsync_i`, mode becomes long if three or more falling bit-clock edges saw the sync high, and short if only one or two did. The new mode applies from the next frame.
- R6: In long mode, if the bit clock is high when `fsync_i` rises, the frame starts at the sync rise. Otherwise it starts at the next rising bit-clock edge. In both cases the first bit is bit 7.
- R7: In long mode `dx_oe_o` clears on the eighth rising bit-clock edge after the frame start.
- R8: `pcm_load_i` high writes `pcm_i` into a staging register. The shifter takes the staging value at frame start, so a load during a frame affects only the next frame.
- R9: With `pwr_en_i` low, `dx_oe_o` is 0 at once and the word in flight is discarded. After the permission returns, the port sends nothing until a new sync, and it is in short mode.
- R10: `dx_o` is 0 whenever `dx_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all other inputs |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwr_en_i | input | 1 | Power-up permission; low forces the output off |
| bclk_i | input | 1 | Transmit bit clock level |
| fsync_i | input | 1 | Transmit frame-sync level |
| pcm_i | input | WORD_W | Parallel code word to stage |
| pcm_load_i | input | 1 | Write strobe for the staging register |
| dx_o | output | 1 | Serial data, MSB first |
| dx_oe_o | output | 1 | Output enable for the serial data line |

## Verification
The assertions assume that `bclk_i`, `fsync_i` and `pwr_en_i` change only between rising edges of `clk_i`. They also assume that every bit-clock phase lasts at least two system-clock cycles. Under those conditions an enable rise always follows a sampled-high bit clock, and data changes only after a sampled bit-clock rise. The bench drives every input on the falling system-clock edge and holds each bit-clock phase for four cycles. For the case where the sync arrives late, it splits a high phase into two cycles before the sync rise and two cycles after it.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  typedef enum logic {
    MODE_SHORT = 1'b0,
    MODE_LONG  = 1'b1
  } sync_mode_e;
endpackage

// File: rtl/pcm_tx_edge.sv
module pcm_tx_edge #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
  assign fall_o = ~lvl_i & lvl_q;
endmodule

// File: rtl/pcm_tx_sync_class.sv
module pcm_tx_sync_class
  import pcm_tx_pkg::*;
#(
  parameter int LONG_MIN = 3,
  localparam int CNT_W = $clog2(LONG_MIN + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_i,
  input  logic       fs_i,
  input  logic       fs_fall_i,
  input  logic       bclk_fall_i,
  output sync_mode_e mode_o,
  output logic       first_fall_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LONG_MIN);

  logic [CNT_W-1:0] cnt_q;
  sync_mode_e       mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= MODE_SHORT;
    end else if (!pwr_i) begin
      cnt_q  <= '0;
      mode_q <= MODE_SHORT;
    end else begin
      if (!fs_i)                              cnt_q <= '0;
      else if (bclk_fall_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      // width is judged once the pulse ends
      if (fs_fall_i) mode_q <= (cnt_q >= CNT_MAX) ? MODE_LONG : MODE_SHORT;
    end
  end

  assign mode_o       = mode_q;
  assign first_fall_o = bclk_fall_i & fs_i & (cnt_q == '0);
endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift #(
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              start_i,
  input  logic              shift_i,
  output logic              msb_o
);
  logic [WORD_W-1:0] stage_q;
  logic [WORD_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stage_q <= '0;
    else if (load_i) stage_q <= word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sr_q <= '0;
    else if (start_i)  sr_q <= stage_q;
    else if (shift_i)  sr_q <= {sr_q[WORD_W-2:0], 1'b0};
  end

  assign msb_o = sr_q[WORD_W-1];
endmodule

// File: rtl/pcm_tx_seq.sv
module pcm_tx_seq
  import pcm_tx_pkg::*;
#(
  parameter int WORD_W = 8,
  localparam int IDX_W = $clog2(WORD_W)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_i,
  input  logic       bclk_i,
  input  logic       bclk_rise_i,
  input  logic       bclk_fall_i,
  input  logic       fs_rise_i,
  input  logic       first_fall_i,
  input  sync_mode_e mode_i,
  output logic       start_o,
  output logic       shift_o,
  output logic       active_o
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORD_W - 1);

  logic             active_q, armed_q, long_q;
  logic [IDX_W-1:0] idx_q;
  logic             start_now, arm_set, last_bit, stop;
  logic             is_long;

  always_comb begin
    is_long   = (mode_i == MODE_LONG);
    // long mode: sync rising while bit clock is already high starts at once
    start_now = !active_q && ((armed_q && bclk_rise_i) ||
                              (is_long && !armed_q && fs_rise_i && bclk_i));
    arm_set   = !active_q && !armed_q &&
                ((!is_long && first_fall_i) || (is_long && fs_rise_i && !bclk_i));
    last_bit  = (idx_q == IDX_LAST);
    shift_o   = active_q && bclk_rise_i && !last_bit;
    stop      = active_q && last_bit && (long_q ? bclk_rise_i : bclk_fall_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      armed_q  <= 1'b0;
      long_q   <= 1'b0;
      idx_q    <= '0;
    end else if (!pwr_i) begin
      active_q <= 1'b0;
      armed_q  <= 1'b0;
      long_q   <= 1'b0;
      idx_q    <= '0;
    end else begin
      if (arm_set) begin
        armed_q <= 1'b1;
        long_q  <= is_long;
      end
      if (start_now) begin
        active_q <= 1'b1;
        armed_q  <= 1'b0;
        idx_q    <= '0;
        if (!armed_q) long_q <= is_long;
      end else if (shift_o) begin
        idx_q <= idx_q + 1'b1;
      end
      if (stop) active_q <= 1'b0;
    end
  end

  assign start_o  = start_now;
  assign active_o = active_q;
endmodule

// File: rtl/pcm_tx_port.sv
module pcm_tx_port
  import pcm_tx_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int LONG_MIN = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_en_i,
  input  logic              bclk_i,
  input  logic              fsync_i,
  input  logic [WORD_W-1:0] pcm_i,
  input  logic              pcm_load_i,
  output logic              dx_o,
  output logic              dx_oe_o
);
  logic [1:0] rise, fall;
  sync_mode_e mode;
  logic       first_fall, start, shift, active, msb;

  pcm_tx_edge #(.N(2)) i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  ({fsync_i, bclk_i}),
    .rise_o (rise),
    .fall_o (fall)
  );

  pcm_tx_sync_class #(.LONG_MIN(LONG_MIN)) i_class (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pwr_i        (pwr_en_i),
    .fs_i         (fsync_i),
    .fs_fall_i    (fall[1]),
    .bclk_fall_i  (fall[0]),
    .mode_o       (mode),
    .first_fall_o (first_fall)
  );

  pcm_tx_seq #(.WORD_W(WORD_W)) i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pwr_i        (pwr_en_i),
    .bclk_i       (bclk_i),
    .bclk_rise_i  (rise[0]),
    .bclk_fall_i  (fall[0]),
    .fs_rise_i    (rise[1]),
    .first_fall_i (first_fall),
    .mode_i       (mode),
    .start_o      (start),
    .shift_o      (shift),
    .active_o     (active)
  );

  pcm_tx_shift #(.WORD_W(WORD_W)) i_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (pcm_load_i),
    .word_i  (pcm_i),
    .start_i (start),
    .shift_i (shift),
    .msb_o   (msb)
  );

  // permission gates the enable without waiting for a clock
  assign dx_oe_o = active & pwr_en_i;
  assign dx_o    = dx_oe_o & msb;
endmodule

// File: rtl/pcm_tx_port_chk.sv
module pcm_tx_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pwr_en_i,
  input logic bclk_i,
  input logic dx_o,
  input logic dx_oe_o
);
  AST_OFF_WHEN_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_i |-> !dx_oe_o);  // R9

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dx_oe_o |-> !dx_o);  // R10

  AST_ENABLE_IN_HIGH_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dx_oe_o) |-> $past(bclk_i));  // R2

  AST_DATA_ONLY_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dx_oe_o && $past(dx_oe_o) && !$past(bclk_i)) |-> $stable(dx_o));  // R3
endmodule

bind pcm_tx_port pcm_tx_port_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pwr_en_i (pwr_en_i),
  .bclk_i   (bclk_i),
  .dx_o     (dx_o),
  .dx_oe_o  (dx_oe_o)
);

// File: tb/test_pcm_tx_port.sv
`timescale 1ns/1ps
module test_pcm_tx_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pwr_en_i = 1'b1;
  logic       bclk_i = 1'b0;
  logic       fsync_i = 1'b0;
  logic [7:0] pcm_i = '0;
  logic       pcm_load_i = 1'b0;
  logic       dx_o, dx_oe_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pcm_tx_port i_pcm_tx_port (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_en_i   (pwr_en_i),
    .bclk_i     (bclk_i),
    .fsync_i    (fsync_i),
    .pcm_i      (pcm_i),
    .pcm_load_i (pcm_load_i),
    .dx_o       (dx_o),
    .dx_oe_o    (dx_oe_o)
  );

  task automatic check(input string req, input logic [1:0] exp);
    n_chk++;
    if ({dx_oe_o, dx_o} !== exp) begin
      n_err++;
      $display("FAIL %s: oe,dx actual=%b expected=%b at %0t", req, {dx_oe_o, dx_o}, exp, $time);
    end
  endtask

  task automatic drive(input logic b, input logic f, input int n);
    bclk_i  = b;
    fsync_i = f;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic load(input logic [7:0] w);
    pcm_i      = w;
    pcm_load_i = 1'b1;
    @(negedge clk_i);
    pcm_load_i = 1'b0;
  endtask

  // kind: 0 short timing, 1 long with sync in low phase, 2 long with sync late in high phase
  task automatic frame(input logic [7:0] w, input int fs_per, input int kind, input string req,
                       input bit ml_en = 1'b0, input logic [7:0] ml_w = '0);
    int base     = (kind == 2) ? 0 : 2;
    int last_h   = base + ((kind == 0) ? 14 : 15);
    int fs_start = (kind == 1) ? 1 : 0;
    for (int h = 0; h < 20; h++) begin
      logic b = (h % 2 == 0);
      logic f = (h >= fs_start) && (h < fs_start + 2 * fs_per);
      logic e_oe;
      logic e_dx;
      if (ml_en && h == 5) begin
        pcm_i      = ml_w;
        pcm_load_i = 1'b1;
      end
      if (kind == 2 && h == 0) begin
        drive(1'b1, 1'b0, 2);
        drive(1'b1, 1'b1, 2);
      end else begin
        drive(b, f, 4);
      end
      pcm_load_i = 1'b0;
      e_oe = (h >= base) && (h <= last_h);
      e_dx = e_oe ? w[7 - (h - base) / 2] : 1'b0;
      check(req, {e_oe, e_dx});
    end
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    check("R1 in reset", 2'b00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after reset", 2'b00);
    drive(1'b1, 1'b0, 4);
    drive(1'b0, 1'b0, 4);
    check("R1 idle no sync", 2'b00);
  endtask

  task automatic t_short;
    load(8'hA5);
    frame(8'hA5, 1, 0, "R2 R3 R4 R10");
    load(8'h3C);
    frame(8'h3C, 1, 0, "R2 R3 R4 R10");
  endtask

  task automatic t_staging;
    load(8'h81);
    frame(8'h81, 1, 0, "R8 current", 1'b1, 8'h7E);
    frame(8'h7E, 1, 0, "R8 next");
  endtask

  task automatic t_two_wide;
    load(8'h66);
    frame(8'h66, 2, 0, "R5 width two");
    frame(8'h66, 1, 0, "R5 still short");
  endtask

  task automatic t_long;
    load(8'hC3);
    frame(8'hC3, 3, 0, "R5 width three");
    load(8'h96);
    frame(8'h96, 3, 1, "R6 R7 clock later");
    load(8'h4B);
    frame(8'h4B, 3, 2, "R6 R7 sync later");
    frame(8'h4B, 1, 1, "R5 R7 last long frame");
    frame(8'h4B, 1, 0, "R5 back to short");
  endtask

  task automatic t_power;
    load(8'hE7);
    frame(8'hE7, 3, 0, "R5 enter long");
    drive(1'b1, 1'b0, 4);
    drive(1'b0, 1'b1, 4);
    drive(1'b1, 1'b1, 4);
    check("R6 partial bit7", 2'b11);
    drive(1'b0, 1'b1, 4);
    drive(1'b1, 1'b1, 4);
    check("R6 partial bit6", 2'b11);
    pwr_en_i = 1'b0;
    #1;
    check("R9 immediate off", 2'b00);
    drive(1'b0, 1'b0, 4);
    check("R9 stays off", 2'b00);
    drive(1'b1, 1'b0, 4);
    check("R9 stays off rise", 2'b00);
    pwr_en_i = 1'b1;
    for (int p = 0; p < 3; p++) begin
      drive(1'b0, 1'b0, 4);
      check("R9 aborted low", 2'b00);
      drive(1'b1, 1'b0, 4);
      check("R9 aborted high", 2'b00);
    end
    drive(1'b0, 1'b0, 4);
    load(8'h18);
    frame(8'h18, 1, 0, "R9 short after power");
  endtask

  initial begin
    t_reset();
    t_short();
    t_staging();
    t_two_wide();
    t_long();
    t_power();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule